// File: doc/BRIEF.md
# Region Chip-Select Decoder with Access Wait States

This block sits between a bus master and a set of external memory regions. For each request it compares the upper address bits against every region's select value. A shared base-address mask limits which bits take part in the compare. The block then drives one chip-select line to the winning region and holds it while that region's access time runs. When the time is up it pulses a done strobe. An address that no enabled region claims produces an error pulse instead, and no chip-select is driven.

Each region has a configuration word and a timing word. Bit 0 of the configuration word enables the region. Bits [2:1] give the memory kind: 0 = SDRAM, 1 = SSRAM, 2 = asynchronous, 3 = synchronous burst. Bits [23:16] hold the 8-bit select value. The timing word feeds the wait count. Which of its fields are used depends on the memory kind and on whether the access is a read or a write. The block handles one access at a time.

Top module: `csd_decoder`

## Requirements
- R1: A region matches when `(addr & (mask << 22)) == ((sel << 22) & (mask << 22))`, where `mask` is the 10-bit mask input and `sel` is configuration bits [23:16]. Address bits below 22 never affect the match, and mask bits set above the select field compare the address against zero.
- R2: A region whose configuration bit 0 is clear never matches.
- R3: When several regions match, the lowest-numbered one gets the chip-select.
- R4: A request that matches no region raises `err_o` for exactly one cycle, in the cycle after the request. No chip-select is asserted for it and no done strobe follows.
- R5: For an asynchronous region (kind 2), a read lasts timing[7:0] + timing[11:8] cycles.
- R6: For an asynchronous region, a write lasts timing[15:12] + timing[19:16] + timing[25:20] cycles.
- R7: For an SDRAM region (kind 0), reads and writes both last 3 + timing[5:4] cycles. No other timing bit has any effect.
- R8: For SSRAM (kind 1) and synchronous burst (kind 3) regions, reads and writes last 2 cycles.
- R9: After reset, all outputs are low. For an accepted request with latency L, exactly one chip-select is high from the cycle after the request through cycle max(L,1), and `done_o` pulses in cycle max(L,1). Both are low in the following cycle.
- R10: A request presented while an access is in progress, or during its done or error cycle, is ignored. It causes no chip-select change, no extra done pulse and no error.
- R11: A computed latency of zero gives `done_o` in the cycle right after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, sampled when the block is idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Bus address |
| mask_i | input | 10 | Shared base-address mask, applied at bit 22 |
| cfg_i | input | 256 | Eight 32-bit region configuration words, region 0 in the low bits |
| tim_i | input | 256 | Eight 32-bit region timing words, region 0 in the low bits |
| cs_o | output | 8 | One-hot chip-select |
| err_o | output | 1 | No-region-matched pulse |
| done_o | output | 1 | Access-complete pulse |

## Verification
The bench builds the block with its defaults: eight regions, a 32-bit address, a 10-bit mask anchored at bit 22, and a 10-bit latency counter. With eight regions, every memory kind can be placed beside a disabled region, a zero-timing region and a duplicate select value all at once. The two mask bits above the 8-bit select field make it possible to show address bits [31:30] failing a match, and then being ignored once masked. The 10-bit counter covers the longest asynchronous read (270 cycles), and a 13-cycle write leaves enough room to fire stray requests into a busy access.

// File: rtl/csd_pkg.sv
package csd_pkg;

   typedef enum logic [1:0] {
      KIND_SDRAM = 2'd0,
      KIND_SSRAM = 2'd1,
      KIND_ASYNC = 2'd2,
      KIND_BURST = 2'd3
   } mem_kind_e;

   // configuration word layout
   localparam int unsigned CFG_EN_BIT   = 0;
   localparam int unsigned CFG_KIND_LSB = 1;
   localparam int unsigned CFG_KIND_W   = 2;
   localparam int unsigned CFG_SEL_LSB  = 16;
   localparam int unsigned CFG_SEL_W    = 8;

   // timing word sub-fields
   localparam int unsigned AS_RD_A_LSB = 0;
   localparam int unsigned AS_RD_A_W   = 8;
   localparam int unsigned AS_RD_B_LSB = 8;
   localparam int unsigned AS_RD_B_W   = 4;
   localparam int unsigned AS_WR_A_LSB = 12;
   localparam int unsigned AS_WR_A_W   = 4;
   localparam int unsigned AS_WR_B_LSB = 16;
   localparam int unsigned AS_WR_B_W   = 4;
   localparam int unsigned AS_WR_C_LSB = 20;
   localparam int unsigned AS_WR_C_W   = 6;
   localparam int unsigned SD_CL_LSB   = 4;
   localparam int unsigned SD_CL_W     = 2;
   localparam int unsigned TIM_USED_W  = AS_WR_C_LSB + AS_WR_C_W;

   localparam int unsigned SD_BASE_LAT = 3;
   localparam int unsigned FIXED_LAT   = 2;

   // longest latency any field combination can give
   localparam int unsigned MAX_LAT =
      ((1 << AS_RD_A_W) - 1) + ((1 << AS_RD_B_W) - 1);

endpackage

// File: rtl/csd_region_match.sv
module csd_region_match #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned MASK_W = 10,
   parameter int unsigned SEL_W  = 8,
   parameter int unsigned SHIFT  = 22
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [MASK_W-1:0] mask_i,
   input  logic              en_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic              hit_o
);
   localparam int unsigned WIN_W = ADDR_W - SHIFT;

   logic [WIN_W-1:0] win_mask;
   logic [WIN_W-1:0] win_cmp;
   logic [WIN_W-1:0] win_addr;

   generate
      if (MASK_W >= WIN_W) begin : g_mask_wide
         assign win_mask = mask_i[WIN_W-1:0];
      end else begin : g_mask_narrow
         assign win_mask = {{(WIN_W-MASK_W){1'b0}}, mask_i};
      end
      if (SEL_W >= WIN_W) begin : g_sel_wide
         assign win_cmp = sel_i[WIN_W-1:0];
      end else begin : g_sel_narrow
         assign win_cmp = {{(WIN_W-SEL_W){1'b0}}, sel_i};
      end
   endgenerate

   assign win_addr = addr_i[ADDR_W-1:SHIFT];
   assign hit_o    = en_i && ((win_addr & win_mask) == (win_cmp & win_mask));

   logic unused_low;
   assign unused_low = ^addr_i[SHIFT-1:0];

endmodule

// File: rtl/csd_pick.sv
module csd_pick #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] hit_i,
   output logic [N-1:0] grant_o,
   output logic         any_o
);
   // lowest set bit isolates the highest-priority region
   assign grant_o = hit_i & (~hit_i + N'(1));
   assign any_o   = |hit_i;
endmodule

// File: rtl/csd_latency.sv
module csd_latency
   import csd_pkg::*;
#(
   parameter int unsigned LAT_W = 10
) (
   input  mem_kind_e              kind_i,
   input  logic                   we_i,
   input  logic [TIM_USED_W-1:0]  tim_i,
   output logic [LAT_W-1:0]       lat_o
);
   logic [LAT_W-1:0] as_rd, as_wr, sd_lat;

   assign as_rd = LAT_W'(tim_i[AS_RD_A_LSB +: AS_RD_A_W])
                + LAT_W'(tim_i[AS_RD_B_LSB +: AS_RD_B_W]);
   assign as_wr = LAT_W'(tim_i[AS_WR_A_LSB +: AS_WR_A_W])
                + LAT_W'(tim_i[AS_WR_B_LSB +: AS_WR_B_W])
                + LAT_W'(tim_i[AS_WR_C_LSB +: AS_WR_C_W]);
   assign sd_lat = LAT_W'(SD_BASE_LAT) + LAT_W'(tim_i[SD_CL_LSB +: SD_CL_W]);

   always_comb begin
      unique case (kind_i)
         KIND_ASYNC: lat_o = we_i ? as_wr : as_rd;
         KIND_SDRAM: lat_o = sd_lat;
         default:    lat_o = LAT_W'(FIXED_LAT);
      endcase
   end
endmodule

// File: rtl/csd_seq.sv
module csd_seq #(
   parameter int unsigned N     = 8,
   parameter int unsigned LAT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_i,
   input  logic             hit_any_i,
   input  logic [N-1:0]     grant_i,
   input  logic [LAT_W-1:0] lat_i,
   output logic [N-1:0]     cs_o,
   output logic             err_o,
   output logic             done_o
);
   logic             busy_q, err_q;
   logic [LAT_W-1:0] rem_q;
   logic [N-1:0]     cs_q;
   logic             accept;
   logic [LAT_W-1:0] lat_eff;

   assign accept  = req_i && !busy_q && !err_q;
   assign lat_eff = (lat_i == '0) ? LAT_W'(1) : lat_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         err_q  <= 1'b0;
         rem_q  <= '0;
         cs_q   <= '0;
      end else begin
         err_q <= accept && !hit_any_i;
         if (accept && hit_any_i) begin
            busy_q <= 1'b1;
            cs_q   <= grant_i;
            rem_q  <= lat_eff - LAT_W'(1);
         end else if (busy_q) begin
            if (rem_q == '0) begin
               busy_q <= 1'b0;
               cs_q   <= '0;
            end else begin
               rem_q <= rem_q - LAT_W'(1);
            end
         end
      end
   end

   assign cs_o   = cs_q;
   assign err_o  = err_q;
   assign done_o = busy_q && (rem_q == '0);

   assert_cs_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |-> ($countones(cs_q) == 1));
   assert_cs_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_q |-> (cs_q == '0));
   assert_done_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> (cs_q == '0) && !done_o);
   assert_err_nocs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_q |-> (cs_q == '0) && !done_o);
   assert_err_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_q |=> !err_q);
   assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && !done_o) |=> (busy_q && $stable(cs_q)));
   assert_zero_lat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && hit_any_i && lat_i == '0) |=> done_o);

endmodule

// File: rtl/csd_decoder.sv
module csd_decoder
   import csd_pkg::*;
#(
   parameter int unsigned N      = 8,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned MASK_W = 10,
   parameter int unsigned SHIFT  = 22,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned LAT_W  = 10
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                req_i,
   input  logic                we_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [MASK_W-1:0]   mask_i,
   input  logic [N*WORD_W-1:0] cfg_i,
   input  logic [N*WORD_W-1:0] tim_i,
   output logic [N-1:0]        cs_o,
   output logic                err_o,
   output logic                done_o
);
   localparam int unsigned CFG_TOP = CFG_SEL_LSB + CFG_SEL_W;

   generate
      if (N < 1) begin : g_bad_n
         $error("csd_decoder: N must be at least 1");
      end
      if (SHIFT + MASK_W > ADDR_W) begin : g_bad_mask
         $error("csd_decoder: mask window exceeds address width");
      end
      if (WORD_W < CFG_TOP || WORD_W < TIM_USED_W) begin : g_bad_word
         $error("csd_decoder: word width too small for fields");
      end
      if ((1 << LAT_W) <= MAX_LAT) begin : g_bad_lat
         $error("csd_decoder: LAT_W cannot hold the longest latency");
      end
   endgenerate

   logic [N-1:0] hit, grant;
   logic         hit_any;

   for (genvar i = 0; i < N; i++) begin : g_region
      csd_region_match #(
         .ADDR_W(ADDR_W), .MASK_W(MASK_W), .SEL_W(CFG_SEL_W), .SHIFT(SHIFT)
      ) u_match (
         .addr_i (addr_i),
         .mask_i (mask_i),
         .en_i   (cfg_i[i*WORD_W + CFG_EN_BIT]),
         .sel_i  (cfg_i[i*WORD_W + CFG_SEL_LSB +: CFG_SEL_W]),
         .hit_o  (hit[i])
      );
   end

   csd_pick #(.N(N)) u_pick (
      .hit_i   (hit),
      .grant_o (grant),
      .any_o   (hit_any)
   );

   // AND-OR select of the winning region's kind and timing
   logic [CFG_KIND_W-1:0] win_kind;
   logic [TIM_USED_W-1:0] win_tim;
   always_comb begin
      win_kind = '0;
      win_tim  = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) begin
            win_kind = win_kind | cfg_i[i*WORD_W + CFG_KIND_LSB +: CFG_KIND_W];
            win_tim  = win_tim  | tim_i[i*WORD_W +: TIM_USED_W];
         end
      end
   end

   logic [LAT_W-1:0] lat;
   csd_latency #(.LAT_W(LAT_W)) u_lat (
      .kind_i (mem_kind_e'(win_kind)),
      .we_i   (we_i),
      .tim_i  (win_tim),
      .lat_o  (lat)
   );

   csd_seq #(.N(N), .LAT_W(LAT_W)) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_i),
      .hit_any_i (hit_any),
      .grant_i   (grant),
      .lat_i     (lat),
      .cs_o      (cs_o),
      .err_o     (err_o),
      .done_o    (done_o)
   );

   // fields that carry no meaning for this block
   logic unused_fields;
   always_comb begin
      unused_fields = 1'b0;
      for (int i = 0; i < N; i++) begin
         unused_fields = unused_fields
            ^ (^cfg_i[i*WORD_W + CFG_KIND_LSB + CFG_KIND_W +: (CFG_SEL_LSB - CFG_KIND_LSB - CFG_KIND_W)])
            ^ (^cfg_i[i*WORD_W + CFG_TOP +: (WORD_W - CFG_TOP)])
            ^ (^tim_i[i*WORD_W + TIM_USED_W +: (WORD_W - TIM_USED_W)]);
      end
   end

   assert_pick_lowest_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_any |-> (((grant & hit) != '0) && (((grant - N'(1)) & hit) == '0)));
   assert_no_hit_no_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_any |-> (grant == '0));
   assert_sdram_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_any && win_kind == KIND_SDRAM) |-> (lat >= LAT_W'(SD_BASE_LAT)));
   assert_fixed_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_any && (win_kind == KIND_SSRAM || win_kind == KIND_BURST))
      |-> (lat == LAT_W'(FIXED_LAT)));

endmodule

// File: tb/tb_csd_decoder.sv
`timescale 1ns/1ps
module tb_csd_decoder;
   localparam int N = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0, we = 1'b0;
   logic [31:0]   addr = '0;
   logic [9:0]    mask = 10'h3FF;
   logic [31:0]   cfg [N];
   logic [31:0]   tim [N];
   logic [N*32-1:0] cfg_flat, tim_flat;
   logic [N-1:0]  cs_o;
   logic          err_o, done_o;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         cfg_flat[i*32 +: 32] = cfg[i];
         tim_flat[i*32 +: 32] = tim[i];
      end
   end

   csd_decoder dut (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .mask_i(mask), .cfg_i(cfg_flat), .tim_i(tim_flat),
      .cs_o(cs_o), .err_o(err_o), .done_o(done_o)
   );

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   bit finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req_tag, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req_tag, what, act, exp);
      end
   endtask

   typedef struct {
      int    drv;
      int    due;
      int    cs_idx;
      bit    is_err;
      string tag;
   } exp_t;
   exp_t sb[$];

   // expected latency straight from the requirement formulas
   function automatic int exp_lat(input logic [31:0] c, input logic [31:0] t, input bit w);
      int k;
      k = int'(c[2:1]);
      if (k == 2) return w ? int'(t[15:12]) + int'(t[19:16]) + int'(t[25:20])
                           : int'(t[7:0]) + int'(t[11:8]);
      if (k == 0) return 3 + int'(t[5:4]);
      return 2;
   endfunction

   function automatic logic [31:0] mk_cfg(input bit en, input int kind, input int sel);
      return (32'(sel) << 16) | (32'(kind) << 1) | 32'(en);
   endfunction

   // monitor: hold check while pending, compare at completion
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done_o || err_o) begin
            if (sb.size() == 0) begin
               check(1'b0, "R10", "unexpected completion", {cs_o, err_o, done_o}, 0);
            end else begin
               exp_t e;
               logic [N-1:0] ecs;
               e = sb.pop_front();
               ecs = e.is_err ? '0 : (N'(1) << e.cs_idx);
               check(cyc == e.due, e.tag, "completion cycle", cyc - e.drv, e.due - e.drv);
               check(cs_o == ecs, e.tag, "chip select at completion", cs_o, ecs);
               check(err_o == e.is_err && done_o == !e.is_err, e.tag, "err/done",
                     {err_o, done_o}, {e.is_err, !e.is_err});
            end
         end else if (sb.size() > 0 && cyc > sb[0].drv) begin
            logic [N-1:0] hcs;
            hcs = sb[0].is_err ? '0 : (N'(1) << sb[0].cs_idx);
            check(cs_o == hcs, "R9", {sb[0].tag, " cs held"}, cs_o, hcs);
         end
      end
   end

   task automatic launch(input logic [31:0] a, input bit w, input int idx, input string tag);
      exp_t e;
      int l;
      @(negedge clk);
      e.drv = cyc;
      e.tag = tag;
      e.is_err = (idx < 0);
      e.cs_idx = (idx < 0) ? 0 : idx;
      l = (idx < 0) ? 1 : exp_lat(cfg[idx], tim[idx], w);
      if (l < 1) l = 1;
      e.due = cyc + l;
      sb.push_back(e);
      req = 1'b1; addr = a; we = w;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic access(input logic [31:0] a, input bit w, input int idx, input string tag);
      launch(a, w, idx, tag);
      drain();
   endtask

   task automatic report();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "R9", "watchdog expired", cyc, 0);
      report();
   end

   initial begin
      cfg[0] = mk_cfg(1, 1, 8'h00); tim[0] = 32'hFFFF_FFFF;
      cfg[1] = mk_cfg(1, 0, 8'h01); tim[1] = 32'h0000_0020;
      cfg[2] = mk_cfg(1, 2, 8'h02); tim[2] = (32'd7 << 20) | (32'd4 << 16) | (32'd2 << 12) | (32'd3 << 8) | 32'd5;
      cfg[3] = mk_cfg(1, 3, 8'h03); tim[3] = 32'h0123_4567;
      cfg[4] = mk_cfg(0, 1, 8'h04); tim[4] = 32'h0;
      cfg[5] = mk_cfg(1, 2, 8'h05); tim[5] = 32'h0;
      cfg[6] = mk_cfg(1, 0, 8'h06); tim[6] = 32'hFFFF_FF3F;
      cfg[7] = mk_cfg(1, 1, 8'h02); tim[7] = 32'h0;

      repeat (3) @(negedge clk);
      check(cs_o == '0 && !err_o && !done_o, "R9", "reset outputs", {cs_o, err_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(cs_o == '0 && !err_o && !done_o, "R9", "idle after reset", {cs_o, err_o, done_o}, 0);

      access(32'h0000_1234, 0, 0, "R8 ssram read");
      access(32'h0040_0000, 0, 1, "R7 sdram read");
      access(32'h0040_0100, 1, 1, "R7 sdram write");
      access(32'h0080_0010, 0, 2, "R5 async read / R3 overlap");
      access(32'h0080_0000, 1, 2, "R6 async write");
      access(32'h00C0_0000, 1, 3, "R8 burst write");
      access(32'h0100_0000, 0, -1, "R2 disabled region");
      access(32'h0140_0000, 0, 5, "R11 zero latency");
      access(32'h0180_0000, 1, 6, "R7 other bits ignored");
      access(32'h3FC0_0000, 0, -1, "R4 no region");
      access(32'h007F_FFFC, 0, 1, "R1 low bits ignored");
      access(32'h8040_0000, 0, -1, "R1 high bits compared");
      mask = 10'h0FF;
      access(32'h8040_0000, 0, 1, "R1 high bits masked");
      mask = 10'h000;
      access(32'h3FC0_0000, 1, 0, "R3 all match lowest wins");
      mask = 10'h3FF;

      // R10: stray requests during a 13-cycle write and in its done cycle
      launch(32'h0080_0000, 1, 2, "R10 long write");
      repeat (3) @(negedge clk);
      req = 1'b1; addr = 32'h0000_0000; we = 1'b0;
      @(negedge clk);
      req = 1'b1; addr = 32'h3FC0_0000;
      @(negedge clk);
      req = 1'b0;
      while (!done_o) @(negedge clk);
      req = 1'b1; addr = 32'h0000_0000;
      @(posedge clk);
      #1 req = 1'b0;
      drain();
      repeat (4) begin
         @(negedge clk);
         check(cs_o == '0 && !done_o && !err_o, "R10", "stray request ignored",
               {cs_o, err_o, done_o}, 0);
      end

      report();
   end
endmodule